// File: doc/BRIEF.md
# Interrupt Status Field with Masked Interrupt and Halt Outputs

This block holds one multi-bit interrupt status field of a register. A bus of hardware event lines feeds a trigger detector. Per bit, the detector fires on a high level, on a rising edge, on a falling edge, or on either edge. Its output is latched into the status field in one of three ways: each bit kept set on its own, the whole trigger value captured once, or no latching at all. Software clears status bits by writing ones. It raises a write strobe and supplies the bits to clear.

Two reductions watch the status field. The interrupt output is an OR over status bits selected by an interrupt select vector. The halt output is an OR over status bits selected by a separate halt select vector. For each vector, a parameter chooses the polarity. In enable polarity, a 1 in the vector admits the bit. In mask polarity, a 1 in the vector blocks the bit.

In whole-value mode, a two-state machine governs capture:
- **ST_EMPTY**: the field is zero and open.
- **ST_HELD**: a value is held.

It has three transitions:
- **CAPTURE** (ST_EMPTY to ST_HELD): a nonzero trigger arrives.
- **RELEASE** (ST_HELD to ST_EMPTY): a software clear leaves zero and no trigger is present.
- **RECAPTURE** (ST_HELD to ST_HELD): a software clear leaves zero in the same cycle as a nonzero trigger, so the new trigger value is loaded.

The per-bit and non-latching modes have no state machine.

Top module: `isf_intr_field`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the status is 0, the interrupt output is low and the halt output is low. The stored previous event value is 0, so an event line that is high at the first sampled edge counts as a rising edge.
- R2: Level trigger (`TRIG_LEVEL`). Every event bit that is 1 at a clock edge is a trigger for that bit.
- R3: Rising trigger (`TRIG_RISE`). A bit triggers only when it was 0 at the previous edge and is 1 at this edge. A line that stays high does not trigger again.
- R4: Falling trigger (`TRIG_FALL`). A bit triggers only when it goes from 1 to 0 between two edges.
- R5: Either-edge trigger (`TRIG_BOTH`). A bit triggers whenever its value differs from the value at the previous edge.
- R6: Per-bit hold (`HOLD_PER_BIT`).
  - A triggered status bit becomes 1 and stays 1 until software clears it.
  - A clear takes effect only when `clr_we_i` is 1, and then removes each bit whose `clr_bits_i` bit is 1.
  - `clr_bits_i` has no effect while `clr_we_i` is 0.
- R7: Per-bit hold. If a trigger and a clear hit the same bit in the same cycle, the bit is 1 afterwards.
- R8: Whole-value hold (`HOLD_WHOLE`).
  - When the status is 0, a nonzero trigger vector is captured whole.
  - Once a value is captured, later triggers are ignored until clears bring the status back to 0.
  - If a clear leaves 0 in the same cycle as a nonzero trigger, that trigger is captured.
- R9: No hold (`HOLD_NONE`). The status equals the trigger vector of the previous edge.
- R10: Interrupt select in enable polarity (`SEL_ENABLE`). `irq_o` is 1 exactly when some status bit is 1 and its `irq_sel_i` bit is 1.
- R11: Interrupt select in mask polarity (`SEL_MASK`). `irq_o` is 1 exactly when some status bit is 1 and its `irq_sel_i` bit is 0.
- R12: The halt output is formed from `halt_sel_i` by the same rule as R10 or R11, under its own polarity parameter. It is independent of `irq_sel_i`.
- R13: Timing.
  - The status changes one edge after the event or clear that causes it.
  - `irq_o` and `halt_o` follow the status and the select vectors with no added register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | WIDTH | Hardware event lines |
| clr_we_i | input | 1 | Software write strobe for the clear |
| clr_bits_i | input | WIDTH | Write-one-to-clear data |
| irq_sel_i | input | WIDTH | Interrupt enable or mask vector |
| halt_sel_i | input | WIDTH | Halt enable or mask vector |
| status_o | output | WIDTH | Current status field |
| irq_o | output | 1 | Interrupt output |
| halt_o | output | 1 | Halt output |

## Verification
An event or clear driven before an edge shows up in the status right after that edge, one cycle later. `irq_o` and `halt_o` follow in the same cycle as the status, or at once after a select vector changes. The bench therefore drives every input on the falling edge and lets exactly one rising edge pass. It then reads status, interrupt and halt together on the next falling edge. The previous-value register adds no extra cycle: an edge trigger compares the line at this edge with the line at the previous edge, and the bench's expected values count edges in that way.

// File: rtl/isf_pkg.sv
package isf_pkg;
    typedef enum logic [1:0] {TRIG_LEVEL, TRIG_RISE, TRIG_FALL, TRIG_BOTH} trig_mode_e;
    typedef enum logic [1:0] {HOLD_PER_BIT, HOLD_WHOLE, HOLD_NONE} hold_mode_e;
    typedef enum logic {SEL_ENABLE, SEL_MASK} sel_pol_e;
    typedef enum logic {ST_EMPTY, ST_HELD} grab_state_e;
endpackage

// File: rtl/isf_trigger.sv
module isf_trigger
    import isf_pkg::*;
#(
    parameter int         WIDTH = 8,
    parameter trig_mode_e MODE  = TRIG_RISE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] evt,
    output logic [WIDTH-1:0] trig
);
    logic [WIDTH-1:0] prev_q;

    // previous sample of the event lines, reset to zero (R1)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= evt;
    end

    generate
        if (MODE == TRIG_LEVEL) begin : g_level
            assign trig = evt;
        end else if (MODE == TRIG_RISE) begin : g_rise
            assign trig = evt & ~prev_q;
            // R3: no rise reported on a bit that was already high
            a_r3_rise_fresh: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> ((trig & $past(evt)) == '0));
        end else if (MODE == TRIG_FALL) begin : g_fall
            assign trig = ~evt & prev_q;
            // R4: a fall needs the bit high at the previous edge
            a_r4_fall_from_high: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> ((trig & ~$past(evt)) == '0));
        end else begin : g_both
            assign trig = evt ^ prev_q;
            // R5: either-edge trigger matches a change since the last edge
            a_r5_any_change: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (trig == (evt ^ $past(evt))));
        end
    endgenerate
endmodule

// File: rtl/isf_hold.sv
module isf_hold
    import isf_pkg::*;
#(
    parameter int         WIDTH = 8,
    parameter hold_mode_e MODE  = HOLD_PER_BIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] trig,
    input  logic             clr_we,
    input  logic [WIDTH-1:0] clr_bits,
    output logic [WIDTH-1:0] status
);
    logic [WIDTH-1:0] status_q;
    logic [WIDTH-1:0] status_d;
    logic [WIDTH-1:0] wipe;
    logic [WIDTH-1:0] kept;

    assign wipe = clr_we ? clr_bits : '0;
    assign kept = status_q & ~wipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    assign status = status_q;

    generate
        if (MODE == HOLD_WHOLE) begin : g_whole
            grab_state_e state_q, state_d;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) state_q <= ST_EMPTY;
                else        state_q <= state_d;
            end

            always_comb begin
                state_d  = state_q;
                status_d = status_q;
                unique case (state_q)
                    ST_EMPTY: begin
                        if (|trig) begin            // CAPTURE
                            state_d  = ST_HELD;
                            status_d = trig;
                        end
                    end
                    ST_HELD: begin
                        if (kept == '0) begin       // RELEASE or RECAPTURE
                            status_d = trig;
                            state_d  = (|trig) ? ST_HELD : ST_EMPTY;
                        end else begin
                            status_d = kept;
                        end
                    end
                endcase
            end

            // R8: state and held value agree
            a_r8_state_tracks: assert property (@(posedge clk) disable iff (!rst_n)
                (state_q == ST_HELD) == (status_q != '0));
            // R8: a held value ignores new triggers when no clear is written
            a_r8_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
                (state_q == ST_HELD && !clr_we) |=> $stable(status_q));
        end else if (MODE == HOLD_PER_BIT) begin : g_bit
            always_comb status_d = kept | trig;

            // R6: without a clear strobe, no set bit drops
            a_r6_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
                !clr_we |=> ((status_q & $past(status_q)) == $past(status_q)));
            // R7: a trigger always leaves its bit set, even under a clear
            a_r7_trig_wins: assert property (@(posedge clk) disable iff (!rst_n)
                (|trig) |=> ((status_q & $past(trig)) == $past(trig)));
        end else begin : g_none
            always_comb status_d = trig;

            // R9: status is the previous trigger vector
            a_r9_follow: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (status_q == $past(trig)));
        end
    endgenerate
endmodule

// File: rtl/isf_reduce.sv
module isf_reduce
    import isf_pkg::*;
#(
    parameter int       WIDTH = 8,
    parameter sel_pol_e POL   = SEL_ENABLE
) (
    input  logic [WIDTH-1:0] vec,
    input  logic [WIDTH-1:0] sel,
    output logic             hit
);
    generate
        if (POL == SEL_ENABLE) begin : g_en
            assign hit = |(vec & sel);
        end else begin : g_mask
            assign hit = |(vec & ~sel);
        end
    endgenerate
endmodule

// File: rtl/isf_intr_field.sv
module isf_intr_field
    import isf_pkg::*;
#(
    parameter int         WIDTH     = 8,
    parameter trig_mode_e TRIG_MODE = TRIG_RISE,
    parameter hold_mode_e HOLD_MODE = HOLD_PER_BIT,
    parameter sel_pol_e   IRQ_POL   = SEL_ENABLE,
    parameter sel_pol_e   HALT_POL  = SEL_MASK
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] evt_i,
    input  logic             clr_we_i,
    input  logic [WIDTH-1:0] clr_bits_i,
    input  logic [WIDTH-1:0] irq_sel_i,
    input  logic [WIDTH-1:0] halt_sel_i,
    output logic [WIDTH-1:0] status_o,
    output logic             irq_o,
    output logic             halt_o
);
    logic [WIDTH-1:0] trig;

    isf_trigger #(.WIDTH(WIDTH), .MODE(TRIG_MODE)) u_trig (
        .clk(clk), .rst_n(rst_n), .evt(evt_i), .trig(trig)
    );

    isf_hold #(.WIDTH(WIDTH), .MODE(HOLD_MODE)) u_hold (
        .clk(clk), .rst_n(rst_n), .trig(trig),
        .clr_we(clr_we_i), .clr_bits(clr_bits_i), .status(status_o)
    );

    isf_reduce #(.WIDTH(WIDTH), .POL(IRQ_POL)) u_irq (
        .vec(status_o), .sel(irq_sel_i), .hit(irq_o)
    );

    isf_reduce #(.WIDTH(WIDTH), .POL(HALT_POL)) u_halt (
        .vec(status_o), .sel(halt_sel_i), .hit(halt_o)
    );

    // R13: an empty field never raises interrupt or halt
    a_r13_quiet_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == '0) |-> (!irq_o && !halt_o));
    // R10: enable polarity with an all-zero select keeps the interrupt low
    a_r10_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (IRQ_POL == SEL_ENABLE && irq_sel_i == '0) |-> !irq_o);
    // R12: mask polarity with an all-ones select keeps halt low
    a_r12_full_mask_no_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (HALT_POL == SEL_MASK && halt_sel_i == '1) |-> !halt_o);
endmodule

// File: tb/isf_intr_field_tb.sv
module isf_intr_field_tb;
    import isf_pkg::*;

    localparam int W = 4;
    localparam int NROWS = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] evt = '0;
    logic         clr_we = 1'b0;
    logic [W-1:0] clr_bits = '0;
    logic [W-1:0] irq_sel = '0;
    logic [W-1:0] halt_sel = '0;

    logic [W-1:0] st_a, st_l, st_f, st_b;
    logic         irq_a, irq_l, irq_f, irq_b;
    logic         halt_a, halt_l, halt_f, halt_b;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    // rise / per-bit / irq enable / halt mask
    isf_intr_field #(.WIDTH(W), .TRIG_MODE(TRIG_RISE), .HOLD_MODE(HOLD_PER_BIT),
                     .IRQ_POL(SEL_ENABLE), .HALT_POL(SEL_MASK)) u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .clr_we_i(clr_we), .clr_bits_i(clr_bits),
        .irq_sel_i(irq_sel), .halt_sel_i(halt_sel), .status_o(st_a), .irq_o(irq_a), .halt_o(halt_a));
    // level / per-bit
    isf_intr_field #(.WIDTH(W), .TRIG_MODE(TRIG_LEVEL), .HOLD_MODE(HOLD_PER_BIT),
                     .IRQ_POL(SEL_ENABLE), .HALT_POL(SEL_MASK)) u_dut_lvl (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .clr_we_i(clr_we), .clr_bits_i(clr_bits),
        .irq_sel_i(irq_sel), .halt_sel_i(halt_sel), .status_o(st_l), .irq_o(irq_l), .halt_o(halt_l));
    // fall / whole-value / irq mask / halt enable
    isf_intr_field #(.WIDTH(W), .TRIG_MODE(TRIG_FALL), .HOLD_MODE(HOLD_WHOLE),
                     .IRQ_POL(SEL_MASK), .HALT_POL(SEL_ENABLE)) u_dut_fall (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .clr_we_i(clr_we), .clr_bits_i(clr_bits),
        .irq_sel_i(irq_sel), .halt_sel_i(halt_sel), .status_o(st_f), .irq_o(irq_f), .halt_o(halt_f));
    // both edges / no hold
    isf_intr_field #(.WIDTH(W), .TRIG_MODE(TRIG_BOTH), .HOLD_MODE(HOLD_NONE),
                     .IRQ_POL(SEL_ENABLE), .HALT_POL(SEL_MASK)) u_dut_both (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .clr_we_i(clr_we), .clr_bits_i(clr_bits),
        .irq_sel_i(irq_sel), .halt_sel_i(halt_sel), .status_o(st_b), .irq_o(irq_b), .halt_o(halt_b));

    // row: {evt, clr_we, clr_bits, irq_sel, halt_sel, exp_status, exp_irq, exp_halt}
    localparam logic [22:0] ROWS [NROWS] = '{
        {4'h0, 1'b0, 4'h0, 4'hF, 4'h0, 4'h0, 1'b0, 1'b0},  // R3 idle
        {4'h3, 1'b0, 4'h0, 4'hF, 4'h0, 4'h3, 1'b1, 1'b1},  // R3 rise, R10/R12
        {4'h3, 1'b0, 4'h0, 4'h4, 4'h3, 4'h3, 1'b0, 1'b0},  // R3 held high, R10/R12 deselect
        {4'h3, 1'b1, 4'h1, 4'h2, 4'hF, 4'h2, 1'b1, 1'b0},  // R6 clear bit0
        {4'h7, 1'b1, 4'h2, 4'h4, 4'hB, 4'h4, 1'b1, 1'b1},  // R3 new rise, R6 clear
        {4'h6, 1'b1, 4'hF, 4'hF, 4'h0, 4'h0, 1'b0, 1'b0},  // R3 fall ignored, R6 clear all
        {4'hE, 1'b1, 4'h8, 4'h8, 4'h7, 4'h8, 1'b1, 1'b1},  // R7 trigger beats clear
        {4'hE, 1'b0, 4'h8, 4'h0, 4'h8, 4'h8, 1'b0, 1'b0},  // R6 clear bits without strobe
        {4'h1, 1'b1, 4'h0, 4'hF, 4'h0, 4'h9, 1'b1, 1'b1},  // R3 bit0 rises again
        {4'h0, 1'b1, 4'hF, 4'hF, 4'h0, 4'h0, 1'b0, 1'b0}   // R6 clear all
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic [W-1:0] e, input logic we, input logic [W-1:0] c);
        evt = e; clr_we = we; clr_bits = c;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset status", st_a | st_l | st_f | st_b, 0);
        check("R1 reset irq/halt", {irq_a, halt_a, irq_f, halt_f}, 0);
        rst_n = 1'b1;

        // table for the rising-edge per-bit instance; R13 sampled one edge later
        for (int i = 0; i < NROWS; i++) begin
            logic [22:0] r;
            r = ROWS[i];
            irq_sel = r[13:10]; halt_sel = r[9:6];
            step(r[22:19], r[18], r[17:14]);
            check($sformatf("R13 row%0d status", i), st_a, r[5:2]);
            check($sformatf("R10 row%0d irq", i), irq_a, r[1]);
            check($sformatf("R12 row%0d halt", i), halt_a, r[0]);
        end

        // fresh reset for the directed mode tests
        rst_n = 1'b0; evt = '0; clr_we = 1'b0; clr_bits = '0;
        irq_sel = '0; halt_sel = 4'hF;
        repeat (2) @(negedge clk);
        check("R1 reset again", st_a | st_l | st_f | st_b, 0);
        rst_n = 1'b1;

        step(4'h5, 1'b0, 4'h0);
        check("R2 level set", st_l, 4'h5);
        check("R5 both rise", st_b, 4'h5);
        check("R4 no fall yet", st_f, 4'h0);
        step(4'h4, 1'b0, 4'h0);
        check("R2 level hold", st_l, 4'h5);
        check("R9 follow trig", st_b, 4'h1);
        check("R8 capture", st_f, 4'h1);
        step(4'h0, 1'b0, 4'h0);
        check("R9 follow fall", st_b, 4'h4);
        check("R8 held ignores trig", st_f, 4'h1);
        check("R11 irq mask open", irq_f, 1);
        check("R12 halt enable", halt_f, 1);
        step(4'h0, 1'b1, 4'h1);
        check("R6 level clear", st_l, 4'h4);
        check("R9 no trig", st_b, 4'h0);
        check("R8 release", st_f, 4'h0);
        step(4'hF, 1'b0, 4'h0);
        check("R2 level all", st_l, 4'hF);
        check("R4 rise ignored", st_f, 4'h0);
        step(4'h0, 1'b0, 4'h0);
        check("R5 both fall", st_b, 4'hF);
        check("R4 fall capture", st_f, 4'hF);
        irq_sel = 4'hC; halt_sel = 4'h3;
        step(4'h0, 1'b1, 4'h3);
        check("R8 partial clear", st_f, 4'hC);
        check("R11 irq masked", irq_f, 0);
        check("R12 halt not enabled", halt_f, 0);
        step(4'hA, 1'b1, 4'hC);
        check("R7 level trig with clear", st_l, 4'hA);
        check("R8 empty again", st_f, 4'h0);
        check("R5 both rise again", st_b, 4'hA);

        finish_run();
    end
endmodule